// File: doc/BRIEF.md
# Byte-Range Checksum Engine

This engine protects a region of a byte-addressed, battery-backed RAM with a 16-bit checksum. A command names an inclusive range through a first and a last address, gives the address of a two-byte checksum field that lies outside the range, and selects one of two operations. The engine reads the range one byte per cycle, adds the bytes into a 16-bit accumulator that wraps on overflow, and takes the bitwise complement of that total as the checksum.

In generate mode the engine writes the checksum into the field, most significant byte first. In verify mode it reads the two field bytes, rebuilds the stored value with the first byte as the upper half, and reports whether that value equals the freshly computed checksum. The engine drives the RAM port itself. The RAM returns read data one cycle after the read strobe. Boot or power-management logic uses the engine to decide whether the contents of the RAM survived a loss of power.

Top module: `cks_engine`

## Requirements
- R1: The accumulated sum covers every byte from the first address to the last address, both included, and is truncated to its low 16 bits.
- R2: The checksum is the bitwise complement of the 16-bit sum. In generate mode (cmdOp = 1) the upper checksum byte is written at the field address and the lower byte at field address + 1. Addresses wrap modulo 2^AW.
- R3: In generate mode the two writes occur on consecutive cycles, the upper byte first.
- R4: In verify mode (cmdOp = 0), valid is high during the done cycle exactly when {byte[field], byte[field+1]} equals the checksum. Valid is low in every other cycle and after every generate.
- R5: Done is high for exactly one cycle. Let n be the number of bytes in the range. Done is high after the (n+4)th clock edge that follows the accepting edge for verify, and after the (n+3)th for generate.
- R6: When the first address is greater than the last address the sum is 0, so generate writes 0xFF to both field bytes.
- R7: Verify never writes the RAM.
- R8: Busy is high from the accepting edge through the done cycle. A command presented while busy is high is ignored, together with all of its fields.
- R9: At most one RAM access occurs per cycle, and a read and a write never occur in the same cycle. Read data is taken one cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command strobe, accepted only while idle |
| cmdOp | input | 1 | 1 = generate, 0 = verify |
| cmdStart | input | AW | First address of the summed range |
| cmdEnd | input | AW | Last address of the summed range |
| cmdLoc | input | AW | Address of the upper checksum byte |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| valid | output | 1 | Verify result, qualified by done |
| memAddr | output | AW | RAM address |
| memRe | output | 1 | RAM read strobe |
| memWe | output | 1 | RAM write strobe |
| memWdata | output | 8 | RAM write data |
| memRdata | input | 8 | RAM read data, one cycle after memRe |

## Verification
If the accumulator drops or repeats a byte, or misses the last byte still in flight in the read pipeline, the error shows at the end of the command: generate writes wrong field bytes, and verify gives the wrong answer on the done cycle. A fault in the range walk or the state sequencing moves the done pulse away from its n+3 or n+4 edge position, and the bench measures that position on every command. A command that slips through while the engine is busy shows at once as stray writes or as a wrong result for the command in flight.

// File: rtl/cks_pkg.sv
`timescale 1ns/1ps
package cks_pkg;

  localparam int SUM_W = 16;

  typedef enum logic [3:0] {
    S_IDLE, S_SUM, S_DRAIN, S_WRHI, S_WRLO, S_RDHI, S_RDLO, S_CMP, S_FIN
  } ctlState_t;

  typedef struct packed {
    logic load;   // latch command fields, clear accumulator
    logic sumRd;  // read next range byte
    logic hiRd;   // read upper field byte
    logic loRd;   // read lower field byte, capture upper
    logic cmp;    // capture lower and compare
    logic wrHi;   // write upper checksum byte
    logic wrLo;   // write lower checksum byte
  } ctlStrobes_t;

endpackage

// File: rtl/cks_dp.sv
`timescale 1ns/1ps
module cks_dp
  import cks_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       st,
  input  logic [AW-1:0]     cmdStart,
  input  logic [AW-1:0]     cmdEnd,
  input  logic [AW-1:0]     cmdLoc,
  output logic              lastAddr,
  output logic              match,
  output logic [AW-1:0]     memAddr,
  output logic              memRe,
  output logic              memWe,
  output logic [7:0]        memWdata,
  input  logic [7:0]        memRdata
);

  localparam int BYTE_PAD = SUM_W - 8;

  logic [AW-1:0]    curAddr, endAddr, locAddr;
  logic [SUM_W-1:0] sumAcc;
  logic [SUM_W-1:0] cksVal;
  logic             accPend;
  logic [7:0]       hiByte;

  assign cksVal   = ~sumAcc;
  assign lastAddr = (curAddr == endAddr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr <= '0;
      endAddr <= '0;
      locAddr <= '0;
      sumAcc  <= '0;
      accPend <= 1'b0;
      hiByte  <= '0;
      match   <= 1'b0;
    end else begin
      accPend <= st.sumRd;
      if (st.load) begin
        curAddr <= cmdStart;
        endAddr <= cmdEnd;
        locAddr <= cmdLoc;
        sumAcc  <= '0;
        match   <= 1'b0;
      end
      if (st.sumRd) curAddr <= curAddr + 1'b1;
      if (accPend)  sumAcc  <= sumAcc + {{BYTE_PAD{1'b0}}, memRdata};
      if (st.loRd)  hiByte  <= memRdata;
      if (st.cmp)   match   <= ({hiByte, memRdata} == cksVal);
    end
  end

  always_comb begin
    if (st.sumRd)                memAddr = curAddr;
    else if (st.hiRd || st.wrHi) memAddr = locAddr;
    else                         memAddr = locAddr + 1'b1;
  end

  assign memRe    = st.sumRd | st.hiRd | st.loRd;
  assign memWe    = st.wrHi | st.wrLo;
  assign memWdata = st.wrHi ? cksVal[SUM_W-1:8] : cksVal[7:0];

  a_r9_rw_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(memRe && memWe));

  a_r2_field_adjacent: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && $past(memWe)) |-> (memAddr == $past(memAddr) + 1'b1));

endmodule

// File: rtl/cks_ctrl.sv
`timescale 1ns/1ps
module cks_ctrl
  import cks_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  input  logic          cmdOp,
  input  logic [AW-1:0] cmdStart,
  input  logic [AW-1:0] cmdEnd,
  input  logic          lastAddr,
  input  logic          match,
  output ctlStrobes_t   st,
  output logic          busy,
  output logic          done,
  output logic          valid
);

  ctlState_t state, nextState;
  logic      opGen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      opGen <= 1'b0;
    end else begin
      state <= nextState;
      if (st.load) opGen <= cmdOp;
    end
  end

  always_comb begin
    nextState = state;
    st        = '0;
    unique case (state)
      S_IDLE: if (cmdValid) begin
        st.load   = 1'b1;
        nextState = (cmdStart > cmdEnd) ? S_DRAIN : S_SUM;
      end
      S_SUM: begin
        st.sumRd = 1'b1;
        if (lastAddr) nextState = S_DRAIN;
      end
      S_DRAIN: nextState = opGen ? S_WRHI : S_RDHI;
      S_WRHI:  begin st.wrHi = 1'b1; nextState = S_WRLO; end
      S_WRLO:  begin st.wrLo = 1'b1; nextState = S_FIN;  end
      S_RDHI:  begin st.hiRd = 1'b1; nextState = S_RDLO; end
      S_RDLO:  begin st.loRd = 1'b1; nextState = S_CMP;  end
      S_CMP:   begin st.cmp  = 1'b1; nextState = S_FIN;  end
      S_FIN:   nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  assign busy  = (state != S_IDLE);
  assign done  = (state == S_FIN);
  assign valid = done & ~opGen & match;

  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r3_lo_follows_hi: assert property (@(posedge clk) disable iff (!rstN)
    st.wrHi |=> st.wrLo);

  a_r7_verify_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (st.wrHi || st.wrLo) |-> opGen);

endmodule

// File: rtl/cks_engine.sv
`timescale 1ns/1ps
module cks_engine
  import cks_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  input  logic          cmdOp,
  input  logic [AW-1:0] cmdStart,
  input  logic [AW-1:0] cmdEnd,
  input  logic [AW-1:0] cmdLoc,
  output logic          busy,
  output logic          done,
  output logic          valid,
  output logic [AW-1:0] memAddr,
  output logic          memRe,
  output logic          memWe,
  output logic [7:0]    memWdata,
  input  logic [7:0]    memRdata
);

  ctlStrobes_t st;
  logic        lastAddr, match;

  cks_ctrl #(.AW(AW)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdStart(cmdStart), .cmdEnd(cmdEnd), .lastAddr(lastAddr),
    .match(match), .st(st), .busy(busy), .done(done), .valid(valid)
  );

  cks_dp #(.AW(AW)) uDp (
    .clk(clk), .rstN(rstN), .st(st), .cmdStart(cmdStart), .cmdEnd(cmdEnd),
    .cmdLoc(cmdLoc), .lastAddr(lastAddr), .match(match),
    .memAddr(memAddr), .memRe(memRe), .memWe(memWe),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  a_r4_valid_with_done: assert property (@(posedge clk) disable iff (!rstN)
    valid |-> done);

  a_r8_done_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

endmodule

// File: tb/tb_cks_engine.sv
`timescale 1ns/1ps
module tb_cks_engine;

  localparam int AW    = 9;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdValid = 1'b0, cmdOp = 1'b0;
  logic [AW-1:0] cmdStart = '0, cmdEnd = '0, cmdLoc = '0;
  logic          busy, done, valid;
  logic [AW-1:0] memAddr;
  logic          memRe, memWe;
  logic [7:0]    memWdata;
  logic [7:0]    memRdata = '0;
  logic [7:0]    mem [DEPTH];

  int checks = 0, errors = 0;
  int wrTotal = 0;

  always #2.5 clk = ~clk;

  cks_engine #(.AW(AW)) dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdStart(cmdStart), .cmdEnd(cmdEnd), .cmdLoc(cmdLoc),
    .busy(busy), .done(done), .valid(valid),
    .memAddr(memAddr), .memRe(memRe), .memWe(memWe),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  always @(posedge clk) begin
    if (memWe) begin
      mem[memAddr] <= memWdata;
      wrTotal      <= wrTotal + 1;
    end
    if (memRe) memRdata <= mem[memAddr];
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expCks(input int s, input int e);
    logic [15:0] acc = '0;
    for (int i = s; i <= e; i++) acc = acc + 16'(mem[i]);
    return ~acc;
  endfunction

  // Runs one command; inj > 0 presents a stray command at that cycle.
  task automatic runOp(input logic op, input int s, input int e, input int l,
                       input int inj, input string tag);
    logic [15:0] cks;
    logic        expValid;
    int          n, cyc, wrBase, expCyc;
    cks      = expCks(s, e);
    expValid = ({mem[(l) % DEPTH], mem[(l + 1) % DEPTH]} == cks);
    n        = (s <= e) ? (e - s + 1) : 0;
    expCyc   = op ? n + 4 : n + 5;
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op;
    cmdStart = AW'(s); cmdEnd = AW'(e); cmdLoc = AW'(l);
    cyc = 0; wrBase = wrTotal;
    forever begin
      @(posedge clk); cyc++;
      @(negedge clk);
      cmdValid = 1'b0;
      if (cyc == 1) begin
        chk(busy === 1'b1, {tag, " R8 busy after accept"}, busy, 1);
        chk(valid === 1'b0, {tag, " R4 valid low outside done"}, valid, 0);
      end
      if (done === 1'b1) break;
      if (inj > 0 && cyc == inj) begin
        cmdValid = 1'b1; cmdOp = ~op;
        cmdStart = '0; cmdEnd = AW'(DEPTH - 1); cmdLoc = AW'(s);
      end
      if (cyc > 4000) break;
    end
    chk(cyc == expCyc, {tag, " R5 done latency"}, cyc, expCyc);
    if (op) begin
      chk(valid === 1'b0, {tag, " R4 valid low after generate"}, valid, 0);
      chk({mem[l % DEPTH], mem[(l + 1) % DEPTH]} == cks,
          {tag, " R2 written field"},
          {mem[l % DEPTH], mem[(l + 1) % DEPTH]}, cks);
      chk(wrTotal - wrBase == 2, {tag, " R3 two writes"}, wrTotal - wrBase, 2);
    end else begin
      chk(valid === expValid, {tag, " R4 verify result"}, valid, expValid);
      chk(wrTotal - wrBase == 0, {tag, " R7 no write in verify"},
          wrTotal - wrBase, 0);
    end
    @(negedge clk);
    chk(done === 1'b0, {tag, " R5 done single cycle"}, done, 0);
    chk(busy === 1'b0, {tag, " R8 idle after done"}, busy, 0);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && valid === 1'b0 && memWe === 1'b0,
        "R8 reset idle", {busy, done, valid, memWe}, 0);
    rstN = 1'b1;

    // R1 R2: generate then verify the same region
    runOp(1'b1, 10, 40, 100, 0, "gen basic");
    runOp(1'b0, 10, 40, 100, 0, "ver basic");
    // R4: corrupt one byte in range, verify must fail
    mem[25] = mem[25] ^ 8'h01;
    runOp(1'b0, 10, 40, 100, 0, "ver corrupt");
    // R1: single-byte range
    runOp(1'b1, 7, 7, 200, 0, "gen single");
    runOp(1'b0, 7, 7, 200, 0, "ver single");
    // R6: start greater than end
    runOp(1'b1, 50, 20, 300, 0, "R6 gen empty");
    chk(mem[300] == 8'hFF && mem[301] == 8'hFF, "R6 empty field",
        {mem[300], mem[301]}, 16'hFFFF);
    runOp(1'b0, 50, 20, 300, 0, "R6 ver empty");
    // R1: sum wraps past 16 bits
    for (int i = 0; i < DEPTH - 2; i++) mem[i] = 8'hFF;
    runOp(1'b1, 0, DEPTH - 3, DEPTH - 2, 0, "R1 gen wrap");
    runOp(1'b0, 0, DEPTH - 3, DEPTH - 2, 0, "R1 ver wrap");
    // R2: field wraps at the top of the address space
    runOp(1'b1, 5, 30, DEPTH - 1, 0, "R2 gen field wrap");
    // R8: stray commands while busy
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'($urandom);
    runOp(1'b0, 60, 90, 400, 3, "R8 ver stray");
    runOp(1'b1, 60, 90, 400, 6, "R8 gen stray");
    runOp(1'b0, 60, 90, 400, 2, "R8 ver after stray");

    // constrained random mix
    for (int k = 0; k < 40; k++) begin
      int s, e, l;
      logic op;
      s  = int'($urandom_range(0, 399));
      e  = int'($urandom_range(0, 399));
      l  = int'($urandom_range(400, DEPTH - 2));
      op = 1'($urandom);
      if (!op && $urandom_range(0, 1) == 1) begin
        logic [15:0] c;
        c = expCks(s, e);
        mem[l] = c[15:8]; mem[l + 1] = c[7:0];
      end
      runOp(op, s, e, l, 0, "rand");
      if ($urandom_range(0, 3) == 0) mem[$urandom_range(0, 399)] = 8'($urandom);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule